// File: doc/BRIEF.md
# Five-Function ALU with Flags

This block is a 32-bit arithmetic-logic unit that runs five functions: bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than. A 3-bit function code selects the function. With the result it reports three flags: a zero flag, the carry out of the adder's top bit, and a signed-overflow flag. Subtraction goes through the same ripple adder as addition. The top bit of the function code acts as a negate-B control. It inverts the B operand and also feeds a carry of 1 into bit 0, so the adder forms A + ~B + 1.

The computation itself is combinational. The top level registers the result and all three flags, so a value shows up at the outputs one clock after the operands and code are applied. That register makes the block usable in timing tests. An active-low synchronous reset clears every output.

Top module: `alu_flagged_unit`

## Requirements
- R1: Code 3'b000 gives the bitwise AND of A and B. Overflow and carry are both 0.
- R2: Code 3'b001 gives the bitwise OR of A and B. Overflow and carry are both 0.
- R3: Code 3'b010 gives A + B modulo 2^32. The carry output is the carry out of bit 31 of that sum.
- R4: Code 3'b110 gives A - B modulo 2^32, formed as A + ~B + 1. The carry output is the carry out of bit 31 of that sum, so it is 1 whenever A >= B unsigned.
- R5: Code 3'b111 gives a result whose bit 0 equals bit 31 of A - B and whose bits 31..1 are 0. Overflow and carry are both 0.
- R6: The zero flag is 1 exactly when all 32 result bits are 0.
- R7: For code 3'b010, overflow is 1 exactly when A and B have the same sign bit and the sum's sign bit differs from it. Operands of opposite sign never overflow.
- R8: For code 3'b110, overflow is 1 exactly when A and B have different sign bits and the difference's sign bit differs from A's.
- R9: For the AND, OR and set-on-less-than codes, both the carry and overflow outputs are 0.
- R10: The unused codes 3'b011, 3'b100 and 3'b101 give a result of 0, a zero flag of 1, and carry and overflow of 0.
- R11: All outputs are registered. Their values reflect the inputs that were present at the previous rising clock edge. While rst_n is 0 at an edge, every output becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| op_i | input | 3 | Function code |
| result_o | output | 32 | Registered result |
| zero_o | output | 1 | Registered zero flag |
| carry_o | output | 1 | Registered adder carry out of bit 31 |
| ovf_o | output | 1 | Registered signed-overflow flag |

## Verification
The properties compare the registered outputs against the operands and code captured one edge earlier. They assume those inputs are stable and known at every rising edge once reset is released. They also assume that the edge after reset release is the first one whose inputs count. The stimulus meets this by changing inputs only on falling edges and by driving every code value, the three unused ones included, with fully defined random or directed operands. Directed vectors cover the sign-boundary operands where the overflow and carry rules meet: 0x7FFFFFFF, 0x80000000, 0xFFFFFFFF and equal operands.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int FN_W = 3;

    localparam logic [FN_W-1:0] FN_AND = 3'b000;
    localparam logic [FN_W-1:0] FN_OR  = 3'b001;
    localparam logic [FN_W-1:0] FN_ADD = 3'b010;
    localparam logic [FN_W-1:0] FN_SUB = 3'b110;
    localparam logic [FN_W-1:0] FN_SLT = 3'b111;

    // bit of the function code that negates B and injects the carry
    localparam int NEG_BIT = FN_W - 1;
endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sel_or_i,
    output logic [WIDTH-1:0] y_o
);
    always_comb begin
        if (sel_or_i) y_o = a_i | b_i;
        else          y_o = a_i & b_i;
    end
endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    logic [WIDTH:0] chain;

    assign chain[0] = cin_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum_o[i]     = a_i[i] ^ b_i[i] ^ chain[i];
        assign chain[i+1]   = (a_i[i] & b_i[i]) | (chain[i] & (a_i[i] ^ b_i[i]));
    end

    assign cout_o = chain[WIDTH];
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] result_i,
    input  logic             arith_i,
    input  logic             a_msb_i,
    input  logic             b_eff_msb_i,
    input  logic             sum_msb_i,
    output logic             zero_o,
    output logic             ovf_o
);
    always_comb begin
        zero_o = ~(|result_i);
        // overflow: adder inputs agree in sign, sum disagrees
        ovf_o  = arith_i & (a_msb_i == b_eff_msb_i) & (sum_msb_i != a_msb_i);
    end
endmodule

// File: rtl/alu_flagged_unit.sv
module alu_flagged_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [FN_W-1:0]  op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             carry_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] result;
        logic             zero;
        logic             carry;
        logic             ovf;
    } alu_out_t;

    alu_out_t out_d, out_q;

    logic             negate;
    logic             is_arith;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] logic_y;
    logic [WIDTH-1:0] sum;
    logic             cout;
    logic [WIDTH-1:0] result_mux;
    logic             zero_f;
    logic             ovf_f;

    assign negate   = op_i[NEG_BIT];
    assign is_arith = (op_i == FN_ADD) || (op_i == FN_SUB);
    assign b_eff    = negate ? ~b_i : b_i;

    alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .a_i      (a_i),
        .b_i      (b_i),
        .sel_or_i (op_i[0]),
        .y_o      (logic_y)
    );

    alu_ripple_adder #(.WIDTH(WIDTH)) u_adder (
        .a_i    (a_i),
        .b_i    (b_eff),
        .cin_i  (negate),
        .sum_o  (sum),
        .cout_o (cout)
    );

    always_comb begin
        case (op_i)
            FN_AND, FN_OR:  result_mux = logic_y;
            FN_ADD, FN_SUB: result_mux = sum;
            FN_SLT:         result_mux = {{(WIDTH-1){1'b0}}, sum[MSB]};
            default:        result_mux = '0;
        endcase
    end

    alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
        .result_i    (result_mux),
        .arith_i     (is_arith),
        .a_msb_i     (a_i[MSB]),
        .b_eff_msb_i (b_eff[MSB]),
        .sum_msb_i   (sum[MSB]),
        .zero_o      (zero_f),
        .ovf_o       (ovf_f)
    );

    always_comb begin
        out_d        = out_q;
        out_d.result = result_mux;
        out_d.zero   = zero_f;
        out_d.carry  = is_arith & cout;
        out_d.ovf    = ovf_f;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result_o = out_q.result;
    assign zero_o   = out_q.zero;
    assign carry_o  = out_q.carry;
    assign ovf_o    = out_q.ovf;

    // ---------------- assertions ----------------

    // R3: registered sum and carry match A + B captured one edge earlier
    p_add_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == FN_ADD) |->
            ({carry_o, result_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)})));

    // R5: set-on-less-than clears all upper result bits
    p_slt_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == FN_SLT) |-> (result_o[MSB:1] == '0));

    // R6: zero flag agrees with the registered result
    p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (zero_o == (result_o == '0)));

    // R7: adding operands of opposite sign never overflows
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == FN_ADD && ($past(a_i[MSB]) != $past(b_i[MSB])))
            |-> !ovf_o);

    // R8: subtracting operands of equal sign never overflows
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_i) == FN_SUB && ($past(a_i[MSB]) == $past(b_i[MSB])))
            |-> !ovf_o);

    // R9: logic and compare functions report no carry or overflow
    p_quiet_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_i) == FN_AND || $past(op_i) == FN_OR ||
                          $past(op_i) == FN_SLT)) |-> (!carry_o && !ovf_o));

    // R10: unused codes give a zero result with quiet flags
    p_unused_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(op_i) == 3'b011 || $past(op_i) == 3'b100 ||
                          $past(op_i) == 3'b101))
            |-> (result_o == '0 && zero_o && !carry_o && !ovf_o));

    // R11: reset clears every output at the following edge
    p_reset_clear_r11: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> (result_o == '0 && !zero_o && !carry_o && !ovf_o));
endmodule

// File: tb/tb_alu_flagged_unit.sv
module tb_alu_flagged_unit;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [2:0]   op = '0;
    logic [W-1:0] result;
    logic         zero, carry, ovf;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    alu_flagged_unit #(.WIDTH(W)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .a_i      (a),
        .b_i      (b),
        .op_i     (op),
        .result_o (result),
        .zero_o   (zero),
        .carry_o  (carry),
        .ovf_o    (ovf)
    );

    typedef struct packed {
        logic [W-1:0] r;
        logic         z;
        logic         c;
        logic         v;
    } exp_t;

    function automatic exp_t model(input logic [W-1:0] x, input logic [W-1:0] y,
                                   input logic [2:0] f);
        exp_t e;
        logic [W:0] s;
        e = '0;
        case (f)
            3'b000: e.r = x & y;                                  // R1
            3'b001: e.r = x | y;                                  // R2
            3'b010: begin                                         // R3, R7
                s   = {1'b0, x} + {1'b0, y};
                e.r = s[W-1:0];
                e.c = s[W];
                e.v = (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
            end
            3'b110: begin                                         // R4, R8
                s   = {1'b0, x} + {1'b0, ~y} + 1;
                e.r = s[W-1:0];
                e.c = s[W];
                e.v = (x[W-1] != y[W-1]) && (s[W-1] != x[W-1]);
            end
            3'b111: begin                                         // R5
                s   = {1'b0, x} - {1'b0, y};
                e.r = {{(W-1){1'b0}}, s[W-1]};
            end
            default: e.r = '0;                                    // R10
        endcase
        e.z = (e.r == '0);                                        // R6
        return e;
    endfunction

    function automatic string res_tag(input logic [2:0] f);
        case (f)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b110:  return "R4";
            3'b111:  return "R5";
            default: return "R10";
        endcase
    endfunction

    function automatic string cv_tag(input logic [2:0] f, input bit is_ovf);
        if (f == 3'b010) return is_ovf ? "R7" : "R3";
        if (f == 3'b110) return is_ovf ? "R8" : "R4";
        if (f == 3'b000 || f == 3'b001 || f == 3'b111) return "R9";
        return "R10";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic run_vec(input logic [W-1:0] x, input logic [W-1:0] y,
                           input logic [2:0] f);
        exp_t e;
        @(negedge clk);
        a  = x;
        b  = y;
        op = f;
        e  = model(x, y, f);
        @(negedge clk);   // R11: one rising edge between drive and sample
        check(res_tag(f), "result", result, e.r);
        check("R6", "zero", {31'b0, zero}, {31'b0, e.z});
        check(cv_tag(f, 1'b0), "carry", {31'b0, carry}, {31'b0, e.c});
        check(cv_tag(f, 1'b1), "ovf", {31'b0, ovf}, {31'b0, e.v});
    endtask

    initial begin
        logic [2:0] f;
        logic [W-1:0] x, y;
        void'($urandom(32'd20240611));

        // R11: outputs held at zero while reset is low, with live inputs
        a = 32'h0000_0005; b = 32'h0000_0003; op = 3'b010;
        repeat (3) @(negedge clk);
        check("R11", "reset result", result, '0);
        check("R11", "reset flags", {29'b0, zero, carry, ovf}, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // directed corner cases
        run_vec(32'hF0F0_1234, 32'h0FF0_FF00, 3'b000);   // R1
        run_vec(32'h0000_0000, 32'hFFFF_FFFF, 3'b000);   // R1 zero result
        run_vec(32'hF000_0001, 32'h0000_1230, 3'b001);   // R2
        run_vec(32'h7FFF_FFFF, 32'h0000_0001, 3'b010);   // R7 positive overflow
        run_vec(32'h8000_0000, 32'h8000_0000, 3'b010);   // R7 negative overflow, zero
        run_vec(32'hFFFF_FFFF, 32'h0000_0001, 3'b010);   // R3 carry, zero, no ovf
        run_vec(32'h7FFF_FFFF, 32'h8000_0000, 3'b010);   // R7 opposite signs
        run_vec(32'h1234_5678, 32'h1234_5678, 3'b110);   // R4 equal: zero, carry 1
        run_vec(32'h8000_0000, 32'h0000_0001, 3'b110);   // R8 overflow
        run_vec(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110);   // R8 overflow
        run_vec(32'h0000_0001, 32'h0000_0002, 3'b110);   // R4 borrow: carry 0
        run_vec(32'hFFFF_FFFF, 32'h0000_0001, 3'b111);   // R5 -1 < 1
        run_vec(32'h0000_0005, 32'h0000_0003, 3'b111);   // R5 5 < 3 false
        run_vec(32'h0000_0007, 32'h0000_0007, 3'b111);   // R5 equal
        run_vec(32'hDEAD_BEEF, 32'h1234_5678, 3'b011);   // R10
        run_vec(32'hFFFF_FFFF, 32'h0000_0001, 3'b100);   // R10 negate bit set
        run_vec(32'h7FFF_FFFF, 32'h7FFF_FFFF, 3'b101);   // R10

        // constrained random over all codes, with sign-boundary bias
        for (int i = 0; i < 3000; i++) begin
            f = 3'($urandom_range(0, 7));
            x = $urandom();
            y = $urandom();
            if ($urandom_range(0, 7) == 0) x = {x[W-1], {(W-1){~x[W-1]}}};
            if ($urandom_range(0, 7) == 0) y = x;
            run_vec(x, y, f);
        end

        // R11: reset again mid-run clears registered state
        @(negedge clk);
        a = 32'hFFFF_FFFF; b = 32'h0000_0001; op = 3'b010;
        rst_n = 1'b0;
        @(negedge clk);
        check("R11", "re-reset result", result, '0);
        check("R11", "re-reset flags", {29'b0, zero, carry, ovf}, '0);
        rst_n = 1'b1;
        run_vec(32'h0000_0002, 32'h0000_0003, 3'b010);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule